// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This controller sits beside the decode stage of a five-stage in-order pipeline. The stages are fetch, decode/register-read, ALU, data memory and register write. Every cycle it compares the source registers of the instruction being decoded with the destinations of the three older instructions in the ALU, data-memory and register-write stages. From that comparison it picks where each ALU operand will come from on the next cycle. The choices are the register file, the latch at the ALU output, or the latch at the data-memory output. When the right value does not exist yet, it stalls the front end for one cycle.

The selects are registered, so they always describe the instruction now in the ALU stage. A separate registered flag tells the data-memory stage to take store data from the data-memory output latch. This lets a store that directly follows a load of its data register go ahead without a bubble. During a stall the fetch address and the fetch/decode latch hold, and the ALU stage receives a bubble whose selects point at the register file. The two parameters are set when the controller is built. STORE_BYPASS turns the late store-data path on or off. RF_WRITE_FIRST says whether the register file writes early in the cycle (so a reader in decode sees the value) or late (so the reader must wait one cycle). All control pins are plain level signals with no handshake, because the controller follows the pipeline's own advance.

Top module: `bypass_hazard_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both ALU selects read 0 and the store-data flag, the stall and the bubble read 0.
- R2: Select encoding is 0 = register file, 1 = ALU output latch, 2 = data-memory output latch. If the instruction in the ALU stage writes a used, non-zero source of the decoded instruction and is not a load, that operand's select is 1 on the next cycle, with no stall.
- R3: If the nearest writer of a used, non-zero source is in the data-memory stage, that operand's select is 2 on the next cycle. This holds whether or not that writer is a load.
- R4: If the only writer of a source is in the register-write stage, that operand reads the register file (select 0) with no stall when RF_WRITE_FIRST=1. When RF_WRITE_FIRST=0 the front end stalls for one cycle instead.
- R5: When several older stages write the same source register, the youngest one wins: ALU stage, then data memory, then register write.
- R6: Register 0 never causes a bypass or a stall, whatever the older stages write.
- R7: A load in the ALU stage whose destination is a used ALU operand of the decoded instruction (operand a, or operand b when it is not store data) raises the stall for that cycle. When the load reaches data memory on the next cycle, the same source selects 2.
- R8: In a stall cycle the ALU stage is given a bubble: on the next cycle both selects are 0, and two cycles later the store-data flag is 0.
- R9: Operand b is marked as store data by the decode-stage flag. With STORE_BYPASS=1, a store whose data register is written by a load in the ALU stage does not stall. Its b select is 0, and the store-data flag is 1 two cycles later, when the store is in data memory. With STORE_BYPASS=0 this case stalls.
- R10: An older instruction with its write-enable low is never treated as a producer.
- R11: A source whose use flag is low is never forwarded and never stalls.
- R12: The two operands are resolved independently. One may take the ALU latch while the other takes the data-memory latch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_src_a | input | RW | Decode-stage source a register |
| dr_src_b | input | RW | Decode-stage source b register |
| dr_use_a | input | 1 | Source a is read |
| dr_use_b | input | 1 | Source b is read |
| dr_b_is_sdata | input | 1 | Source b is only store data, needed in data memory |
| ex_dst | input | RW | Destination of the ALU-stage instruction |
| ex_wen | input | 1 | ALU-stage instruction writes a register |
| ex_load | input | 1 | ALU-stage instruction is a load |
| dm_dst | input | RW | Destination of the data-memory-stage instruction |
| dm_wen | input | 1 | Data-memory-stage instruction writes a register |
| rw_dst | input | RW | Destination of the register-write-stage instruction |
| rw_wen | input | 1 | Register-write-stage instruction writes |
| alu_sel_a | output | 2 | Operand a source for the instruction now in the ALU stage |
| alu_sel_b | output | 2 | Operand b source for the instruction now in the ALU stage |
| dm_sdata_fwd | output | 1 | Store in data memory takes data from the data-memory output latch |
| front_hold | output | 1 | Hold the fetch address and the fetch/decode latch |
| alu_bubble | output | 1 | Load a bubble into the ALU stage |

## Verification
The bench builds two copies with an eight-entry register space (RW = 3), so random register numbers collide often. Both copies see the same stimulus. One copy uses the defaults: store bypass on and early register-file write. The other has STORE_BYPASS=0 and RF_WRITE_FIRST=0. Running both brings the load-to-store stall and the register-write wait into reach next to their bypassed counterparts. It also exercises three-way priority collisions on the same register.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF      = 2'd0,
    SEL_ALU_LAT = 2'd1,
    SEL_DM_LAT  = 2'd2
  } opsel_e;

  localparam int NUM_OPS = 2;
  localparam int NUM_STG = 3;
  localparam int STG_EX  = 0;
  localparam int STG_DM  = 1;
  localparam int STG_RW  = 2;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          use_i,
  input  logic [RW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  logic src_nz;
  assign src_nz = |src;
  assign hit    = use_i & src_nz & wen & (dst == src);
endmodule

// File: rtl/hzd_pick.sv
module hzd_pick
  import hzd_pkg::*;
(
  input  logic   hit_ex,
  input  logic   hit_dm,
  input  logic   drop_ex,
  output opsel_e sel
);
  always_comb begin
    if (hit_ex)      sel = drop_ex ? SEL_RF : SEL_ALU_LAT;
    else if (hit_dm) sel = SEL_DM_LAT;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hzd_stall.sv
module hzd_stall
  import hzd_pkg::*;
#(
  parameter bit STORE_BYPASS   = 1'b1,
  parameter bit RF_WRITE_FIRST = 1'b1
) (
  input  logic [NUM_STG-1:0] hit_a,
  input  logic [NUM_STG-1:0] hit_b,
  input  logic               ex_load,
  input  logic               b_alu,
  output logic               stall,
  output logic               sd_take
);
  localparam bit WAIT_RW = !RF_WRITE_FIRST;

  logic load_a, load_b, need_b_alu, need_b_mem;
  logic wait_a, wait_b, rw_stall;

  assign load_a     = ex_load & hit_a[STG_EX];
  assign need_b_alu = ex_load & hit_b[STG_EX] & b_alu;
  assign need_b_mem = ex_load & hit_b[STG_EX] & ~b_alu;

  generate
    if (STORE_BYPASS) begin : g_late_sdata
      assign load_b  = need_b_alu;
      assign sd_take = need_b_mem;
    end else begin : g_no_late_sdata
      assign load_b  = need_b_alu | need_b_mem;
      assign sd_take = 1'b0;
    end
  endgenerate

  assign wait_a   = hit_a[STG_RW] & ~hit_a[STG_DM] & ~hit_a[STG_EX];
  assign wait_b   = hit_b[STG_RW] & ~hit_b[STG_DM] & ~hit_b[STG_EX];
  assign rw_stall = WAIT_RW & (wait_a | wait_b);

  assign stall = load_a | load_b | rw_stall;
endmodule

// File: rtl/bypass_hazard_ctl.sv
module bypass_hazard_ctl
  import hzd_pkg::*;
#(
  parameter int REG_COUNT      = 32,
  parameter bit STORE_BYPASS   = 1'b1,
  parameter bit RF_WRITE_FIRST = 1'b1,
  localparam int RW            = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dr_src_a,
  input  logic [RW-1:0] dr_src_b,
  input  logic          dr_use_a,
  input  logic          dr_use_b,
  input  logic          dr_b_is_sdata,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] dm_dst,
  input  logic          dm_wen,
  input  logic [RW-1:0] rw_dst,
  input  logic          rw_wen,
  output logic [1:0]    alu_sel_a,
  output logic [1:0]    alu_sel_b,
  output logic          dm_sdata_fwd,
  output logic          front_hold,
  output logic          alu_bubble
);
  logic [RW-1:0]      src_v  [NUM_OPS];
  logic               use_v  [NUM_OPS];
  logic [RW-1:0]      dst_v  [NUM_STG];
  logic               wen_v  [NUM_STG];
  logic [NUM_STG-1:0] hit    [NUM_OPS];
  logic               drop_v [NUM_OPS];
  opsel_e             pick_v [NUM_OPS];
  opsel_e             sel_q  [NUM_OPS];

  logic stall, sd_take, sd_alu_q, sd_dm_q;

  assign src_v[0] = dr_src_a;
  assign src_v[1] = dr_src_b;
  assign use_v[0] = dr_use_a;
  assign use_v[1] = dr_use_b;
  assign dst_v[STG_EX] = ex_dst;
  assign dst_v[STG_DM] = dm_dst;
  assign dst_v[STG_RW] = rw_dst;
  assign wen_v[STG_EX] = ex_wen;
  assign wen_v[STG_DM] = dm_wen;
  assign wen_v[STG_RW] = rw_wen;

  generate
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
      for (genvar st = 0; st < NUM_STG; st++) begin : g_stg
        hzd_match #(.RW(RW)) u_match (
          .src  (src_v[op]),
          .use_i(use_v[op]),
          .dst  (dst_v[st]),
          .wen  (wen_v[st]),
          .hit  (hit[op][st])
        );
      end
      hzd_pick u_pick (
        .hit_ex (hit[op][STG_EX]),
        .hit_dm (hit[op][STG_DM]),
        .drop_ex(drop_v[op]),
        .sel    (pick_v[op])
      );
    end
  endgenerate

  assign drop_v[0] = 1'b0;
  assign drop_v[1] = sd_take;

  hzd_stall #(
    .STORE_BYPASS  (STORE_BYPASS),
    .RF_WRITE_FIRST(RF_WRITE_FIRST)
  ) u_stall (
    .hit_a  (hit[0]),
    .hit_b  (hit[1]),
    .ex_load(ex_load),
    .b_alu  (~dr_b_is_sdata),
    .stall  (stall),
    .sd_take(sd_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q[0] <= SEL_RF;
      sel_q[1] <= SEL_RF;
      sd_alu_q <= 1'b0;
      sd_dm_q  <= 1'b0;
    end else begin
      sd_dm_q <= sd_alu_q;
      if (stall) begin
        sel_q[0] <= SEL_RF;
        sel_q[1] <= SEL_RF;
        sd_alu_q <= 1'b0;
      end else begin
        sel_q[0] <= pick_v[0];
        sel_q[1] <= pick_v[1];
        sd_alu_q <= sd_take;
      end
    end
  end

  assign alu_sel_a    = sel_q[0];
  assign alu_sel_b    = sel_q[1];
  assign dm_sdata_fwd = sd_dm_q;
  assign front_hold   = stall & rst_n;
  assign alu_bubble   = stall & rst_n;
endmodule

// File: rtl/bypass_hazard_chk.sv
module bypass_hazard_chk #(
  parameter int REG_COUNT      = 32,
  parameter bit STORE_BYPASS   = 1'b1,
  parameter bit RF_WRITE_FIRST = 1'b1,
  localparam int RW            = $clog2(REG_COUNT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] dr_src_a,
  input logic [RW-1:0] dr_src_b,
  input logic          dr_use_a,
  input logic          dr_use_b,
  input logic          dr_b_is_sdata,
  input logic [RW-1:0] ex_dst,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [RW-1:0] dm_dst,
  input logic          dm_wen,
  input logic [RW-1:0] rw_dst,
  input logic          rw_wen,
  input logic [1:0]    alu_sel_a,
  input logic [1:0]    alu_sel_b,
  input logic          dm_sdata_fwd,
  input logic          front_hold
);
  logic a_ex, a_dm, a_rw, b_ex;
  assign a_ex = dr_use_a && (dr_src_a != '0) && ex_wen && (ex_dst == dr_src_a);
  assign a_dm = dr_use_a && (dr_src_a != '0) && dm_wen && (dm_dst == dr_src_a);
  assign a_rw = dr_use_a && (dr_src_a != '0) && rw_wen && (rw_dst == dr_src_a);
  assign b_ex = dr_use_b && (dr_src_b != '0) && ex_wen && (ex_dst == dr_src_b);

  p_alu_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ex && !ex_load && !front_hold) |=> (alu_sel_a == 2'd1));

  p_dm_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ex && a_dm && !front_hold) |=> (alu_sel_a == 2'd2));

  p_rw_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rw && !a_ex && !a_dm) |-> (RF_WRITE_FIRST || front_hold));

  p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_src_a == '0 && dr_src_b == '0) |=> (alu_sel_a == 2'd0 && alu_sel_b == 2'd0));

  p_load_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && a_ex) |-> front_hold);

  p_bubble_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    front_hold |=> (alu_sel_a == 2'd0 && alu_sel_b == 2'd0));

  p_bubble_sd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    front_hold |=> ##1 !dm_sdata_fwd);

  p_late_sdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (STORE_BYPASS && ex_load && b_ex && dr_b_is_sdata && !front_hold) |=> ##1 dm_sdata_fwd);
endmodule

bind bypass_hazard_ctl bypass_hazard_chk #(
  .REG_COUNT     (REG_COUNT),
  .STORE_BYPASS  (STORE_BYPASS),
  .RF_WRITE_FIRST(RF_WRITE_FIRST)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dr_src_a     (dr_src_a),
  .dr_src_b     (dr_src_b),
  .dr_use_a     (dr_use_a),
  .dr_use_b     (dr_use_b),
  .dr_b_is_sdata(dr_b_is_sdata),
  .ex_dst       (ex_dst),
  .ex_wen       (ex_wen),
  .ex_load      (ex_load),
  .dm_dst       (dm_dst),
  .dm_wen       (dm_wen),
  .rw_dst       (rw_dst),
  .rw_wen       (rw_wen),
  .alu_sel_a    (alu_sel_a),
  .alu_sel_b    (alu_sel_b),
  .dm_sdata_fwd (dm_sdata_fwd),
  .front_hold   (front_hold)
);

// File: tb/sim_bypass_hazard_ctl.sv
`timescale 1ns/1ps
module sim_bypass_hazard_ctl;
  localparam int NREG = 8;
  localparam int W    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] src_a = '0, src_b = '0, ex_dst = '0, dm_dst = '0, rw_dst = '0;
  logic use_a = 1'b0, use_b = 1'b0, b_sd = 1'b0;
  logic ex_wen = 1'b0, ex_load = 1'b0, dm_wen = 1'b0, rw_wen = 1'b0;

  logic [1:0] sa0, sb0, sa1, sb1;
  logic sd0, sd1, hold0, hold1, bub0, bub1;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  int sd_pend [2];

  always #5 clk = ~clk;

  bypass_hazard_ctl #(.REG_COUNT(NREG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dr_src_a(src_a), .dr_src_b(src_b), .dr_use_a(use_a), .dr_use_b(use_b),
    .dr_b_is_sdata(b_sd),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .dm_dst(dm_dst), .dm_wen(dm_wen), .rw_dst(rw_dst), .rw_wen(rw_wen),
    .alu_sel_a(sa0), .alu_sel_b(sb0), .dm_sdata_fwd(sd0),
    .front_hold(hold0), .alu_bubble(bub0)
  );

  bypass_hazard_ctl #(.REG_COUNT(NREG), .STORE_BYPASS(1'b0), .RF_WRITE_FIRST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .dr_src_a(src_a), .dr_src_b(src_b), .dr_use_a(use_a), .dr_use_b(use_b),
    .dr_b_is_sdata(b_sd),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .dm_dst(dm_dst), .dm_wen(dm_wen), .rw_dst(rw_dst), .rw_wen(rw_wen),
    .alu_sel_a(sa1), .alu_sel_b(sb1), .dm_sdata_fwd(sd1),
    .front_hold(hold1), .alu_bubble(bub1)
  );

  task automatic chk(input string tag, input int k, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s u%0d %s actual=%0d expected=%0d", tag, k, what, act, exp);
    end
  endtask

  // distance (1..3) of the newest writer of a source, 0 when none
  function automatic int nearest(input int src, input int used);
    int d = 0;
    if (used != 0 && src != 0) begin
      if (rw_wen && int'(rw_dst) == src) d = 3;
      if (dm_wen && int'(dm_dst) == src) d = 2;
      if (ex_wen && int'(ex_dst) == src) d = 1;
    end
    return d;
  endfunction

  task automatic model(input int byp, input int wf, output int st, output int oa,
                       output int ob, output int osd);
    int na, nb, take;
    na = nearest(int'(src_a), int'(use_a));
    nb = nearest(int'(src_b), int'(use_b));
    take = (nb == 1 && ex_load && b_sd && byp != 0) ? 1 : 0;
    st = 0;
    if (na == 1 && ex_load) st = 1;
    if (nb == 1 && ex_load && (!b_sd || byp == 0)) st = 1;
    if (wf == 0 && (na == 3 || nb == 3)) st = 1;
    oa = (na == 1) ? 1 : (na == 2) ? 2 : 0;
    ob = (nb == 1) ? (take ? 0 : 1) : (nb == 2) ? 2 : 0;
    osd = take;
    if (st != 0) begin oa = 0; ob = 0; osd = 0; end
  endtask

  task automatic step(input string tag,
                      input int a, input int ua, input int b, input int ub, input int sd,
                      input int ed, input int ew, input int el,
                      input int dd, input int dw, input int rd, input int rwen);
    int st [2]; int oa [2]; int ob [2]; int os [2];
    src_a = W'(a); use_a = ua[0]; src_b = W'(b); use_b = ub[0]; b_sd = sd[0];
    ex_dst = W'(ed); ex_wen = ew[0]; ex_load = el[0];
    dm_dst = W'(dd); dm_wen = dw[0]; rw_dst = W'(rd); rw_wen = rwen[0];
    #1;
    model(1, 1, st[0], oa[0], ob[0], os[0]);
    model(0, 0, st[1], oa[1], ob[1], os[1]);
    chk(tag, 0, "front_hold", int'(hold0), st[0]);
    chk(tag, 0, "alu_bubble", int'(bub0), st[0]);
    chk(tag, 1, "front_hold", int'(hold1), st[1]);
    chk(tag, 1, "alu_bubble", int'(bub1), st[1]);
    @(posedge clk); #1;
    chk(tag, 0, "alu_sel_a", int'(sa0), oa[0]);
    chk(tag, 0, "alu_sel_b", int'(sb0), ob[0]);
    chk(tag, 0, "dm_sdata_fwd", int'(sd0), sd_pend[0]);
    chk(tag, 1, "alu_sel_a", int'(sa1), oa[1]);
    chk(tag, 1, "alu_sel_b", int'(sb1), ob[1]);
    chk(tag, 1, "dm_sdata_fwd", int'(sd1), sd_pend[1]);
    sd_pend[0] = os[0];
    sd_pend[1] = os[1];
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    sd_pend[0] = 0;
    sd_pend[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 0, "alu_sel_a", int'(sa0), 0);
    chk("R1", 0, "alu_sel_b", int'(sb0), 0);
    chk("R1", 0, "dm_sdata_fwd", int'(sd0), 0);
    chk("R1", 0, "front_hold", int'(hold0), 0);
    chk("R1", 1, "front_hold", int'(hold1), 0);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    //      tag   a ua b ub sd  ed ew el  dd dw  rd rw
    step("R2",  3, 1, 1, 1, 0,  3, 1, 0,  0, 0,  0, 0);
    step("R3",  1, 1, 4, 1, 0,  0, 0, 0,  4, 1,  0, 0);
    step("R4",  5, 1, 0, 0, 0,  0, 0, 0,  0, 0,  5, 1);
    step("R5",  6, 1, 6, 1, 0,  6, 1, 0,  6, 1,  6, 1);
    step("R5",  6, 1, 6, 1, 0,  1, 1, 0,  6, 1,  6, 1);
    step("R6",  0, 1, 0, 1, 0,  0, 1, 1,  0, 1,  0, 1);
    step("R7",  2, 1, 7, 1, 0,  2, 1, 1,  0, 0,  0, 0);
    step("R7",  2, 1, 7, 1, 0,  0, 0, 0,  2, 1,  0, 0);
    step("R8",  1, 1, 2, 1, 0,  2, 1, 1,  1, 1,  0, 0);
    step("R8",  0, 0, 0, 0, 0,  0, 0, 0,  0, 0,  0, 0);
    step("R9",  4, 1, 3, 1, 1,  3, 1, 1,  0, 0,  0, 0);
    step("R9",  0, 0, 0, 0, 0,  0, 0, 0,  0, 0,  0, 0);
    step("R9",  0, 0, 0, 0, 0,  0, 0, 0,  0, 0,  0, 0);
    step("R10", 5, 1, 5, 1, 0,  5, 0, 1,  5, 0,  5, 0);
    step("R11", 3, 0, 3, 0, 0,  3, 1, 1,  3, 1,  3, 1);
    step("R12", 2, 1, 4, 1, 0,  2, 1, 0,  4, 1,  0, 0);
    step("R12", 0, 0, 0, 0, 0,  0, 0, 0,  0, 0,  0, 0);
    // randomised mix of all cases, priority collisions dominate (R5)
    for (int i = 0; i < 4000; i++) begin
      step("R5", $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 7),
           $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 1));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule